// File: doc/BRIEF.md
# Clock Stop Gate

This block decides, for a group of derived clock outputs, whether each output toggles, is parked low, or is floated. A free-running reference clock level (`ref_i`) arrives sampled in a faster system clock domain. Each output is produced as a registered copy of that level, ANDed with its own run condition. An asynchronous active-low stop request halts the gated outputs, leaving them at logic 0. Per-output software disable bits park single outputs low. A separate free-running output obeys its own disable bit but ignores the stop request.

The stop request first passes through a synchronizer. It is then captured on a rising edge of the reference and takes effect on the rising edge after that. Run state and disable state change only at a reference rising edge. At that moment every output is low, so no output is ever cut short or started part-way through a high phase.

Floating is kept apart from parking low. Each output has its own drive-enable signal, which the active-low output-enable pin and a global three-state mode code control. A parked output keeps its driver enabled. The block has no data streams, so every pin is a plain level signal.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_ni` is low, every clock output and every drive enable is 0. The internal stop state resets to running.
- R2: Suppose `stop_ni` goes low at least three system cycles before a reference rising edge E0. The gated outputs still give a full high pulse in the reference period that starts at E0. From the next rising edge E1 onward they stay at 0.
- R3: Suppose `stop_ni` returns high at least three system cycles before a reference rising edge E0. The gated outputs stay at 0 for the period that starts at E0. They toggle again from E1.
- R4: `free_clk_o` follows the reference whatever the level of `stop_ni`.
- R5: A clock output rises only while the reference is high and falls only while it is low. Every high pulse therefore spans the whole high phase, and no partial (runt) pulse occurs.
- R6: A value of 1 in `sw_dis_i[i]` holds `gclk_o[i]` at 0, and a value of 1 in `free_dis_i` holds `free_clk_o` at 0. A bit change made while the reference is low takes effect at the next reference rising edge.
- R7: One system cycle after `oe_ni` is sampled low, all drive enables are 0. One cycle after it is sampled high, they are 1, unless R8 applies.
- R8: A `mode_i` value of 2'b11 forces all drive enables to 0 one system cycle later. The values 2'b00, 2'b01 and 2'b10 leave the drivers enabled.
- R9: An output that is parked low by a stop or by a disable bit keeps its drive enable at 1.
- R10: Each clock output is registered. When the output is running, it equals the reference level sampled one system cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock, faster than the reference |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Free-running reference clock level, synchronous to clk_i |
| stop_ni | input | 1 | Asynchronous active-low stop request for the gated outputs |
| sw_dis_i | input | N_GATED | Per-output disable bits, 1 = parked low |
| free_dis_i | input | 1 | Disable bit for the free-running output, 1 = parked low |
| oe_ni | input | 1 | Active-low output enable for all drivers |
| mode_i | input | 2 | Drive mode code, 2'b11 = all outputs floated |
| gclk_o | output | N_GATED | Gated clock values |
| gclk_oe_o | output | N_GATED | Drive enables of the gated outputs, 0 = high impedance |
| free_clk_o | output | 1 | Free-running clock value |
| free_oe_o | output | 1 | Drive enable of the free-running output |

## Verification
Several properties are checked by assertions on every cycle. A clock output may rise only while the reference is high and fall only while it is low. The free output is never high unless the reference was high. The drive enables must follow the output-enable pin and the mode code with one cycle of latency. Other behaviour can only be shown by the bench scenarios: the period-exact latency of stop and release, the free output running through a stop, disable bits taking effect at the next rising edge, and drivers staying enabled while an output is parked.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    DRV_RUN     = 2'b00,
    DRV_RSVD    = 2'b01,
    DRV_RUN_ALT = 2'b10,
    DRV_FLOAT   = 2'b11
  } drv_mode_e;

  localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_edge.sv
module clkstop_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_i;
  end

  assign rise_o = ref_i & ~ref_q;
endmodule

// File: rtl/clkstop_run_pipe.sv
module clkstop_run_pipe #(
  parameter int unsigned N_GATED = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rise_i,
  input  logic               run_req_i,
  input  logic [N_GATED-1:0] dis_i,
  input  logic               free_dis_i,
  output logic               run_nxt_o,
  output logic [N_GATED-1:0] dis_nxt_o,
  output logic               free_dis_nxt_o
);
  logic               run_cap_q;
  logic               run_act_q;
  logic [N_GATED-1:0] dis_q;
  logic               free_dis_q;

  // Capture at one rising edge, apply at the following one.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cap_q  <= 1'b1;
      run_act_q  <= 1'b1;
      dis_q      <= '0;
      free_dis_q <= 1'b0;
    end else if (rise_i) begin
      run_cap_q  <= run_req_i;
      run_act_q  <= run_cap_q;
      dis_q      <= dis_i;
      free_dis_q <= free_dis_i;
    end
  end

  always_comb begin
    run_nxt_o      = rise_i ? run_cap_q  : run_act_q;
    dis_nxt_o      = rise_i ? dis_i      : dis_q;
    free_dis_nxt_o = rise_i ? free_dis_i : free_dis_q;
  end
endmodule

// File: rtl/clkstop_cell.sv
module clkstop_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic en_i,
  input  logic drv_i,
  output logic clk_o,
  output logic oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      clk_o <= ref_i & en_i;
      oe_o  <= drv_i;
    end
  end
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned N_GATED     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_i,
  input  logic               stop_ni,
  input  logic [N_GATED-1:0] sw_dis_i,
  input  logic               free_dis_i,
  input  logic               oe_ni,
  input  logic [MODE_W-1:0]  mode_i,
  output logic [N_GATED-1:0] gclk_o,
  output logic [N_GATED-1:0] gclk_oe_o,
  output logic               free_clk_o,
  output logic               free_oe_o
);
  logic               run_req;
  logic               rise;
  logic               run_nxt;
  logic [N_GATED-1:0] dis_nxt;
  logic               free_dis_nxt;
  logic               drive;
  drv_mode_e          mode;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stop_ni), .q_o(run_req)
  );

  clkstop_edge i_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .rise_o(rise)
  );

  clkstop_run_pipe #(.N_GATED(N_GATED)) i_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .run_req_i(run_req),
    .dis_i(sw_dis_i), .free_dis_i(free_dis_i),
    .run_nxt_o(run_nxt), .dis_nxt_o(dis_nxt), .free_dis_nxt_o(free_dis_nxt)
  );

  assign mode  = drv_mode_e'(mode_i);
  assign drive = oe_ni & (mode != DRV_FLOAT);

  generate
    for (genvar i = 0; i < N_GATED; i++) begin : g_out
      clkstop_cell i_cell (
        .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i),
        .en_i(run_nxt & ~dis_nxt[i]), .drv_i(drive),
        .clk_o(gclk_o[i]), .oe_o(gclk_oe_o[i])
      );
    end
  endgenerate

  clkstop_cell i_free (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i),
    .en_i(~free_dis_nxt), .drv_i(drive),
    .clk_o(free_clk_o), .oe_o(free_oe_o)
  );
endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int unsigned N_GATED = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ref_i,
  input logic               oe_ni,
  input logic [1:0]         mode_i,
  input logic [N_GATED-1:0] gclk_o,
  input logic [N_GATED-1:0] gclk_oe_o,
  input logic               free_clk_o,
  input logic               free_oe_o
);
  generate
    for (genvar i = 0; i < N_GATED; i++) begin : g_bit
      a_r5_rise_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gclk_o[i]) |-> $past(ref_i));
      a_r5_fall_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(gclk_o[i]) |-> !$past(ref_i));
    end
  endgenerate

  a_r4_free_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_clk_o |-> $past(ref_i));

  a_r7_oe_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(oe_ni) |-> (gclk_oe_o == '0) && !free_oe_o);

  a_r8_mode_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'b11) |-> (gclk_oe_o == '0) && !free_oe_o);

  a_r9_drive_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(oe_ni) && ($past(mode_i) != 2'b11))
      |-> (&gclk_oe_o) && free_oe_o);
endmodule

bind clkstop_gate clkstop_gate_chk #(.N_GATED(N_GATED)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .oe_ni(oe_ni),
  .mode_i(mode_i), .gclk_o(gclk_o), .gclk_oe_o(gclk_oe_o),
  .free_clk_o(free_clk_o), .free_oe_o(free_oe_o)
);

// File: tb/test_clkstop_gate.sv
module test_clkstop_gate;
  localparam int N = 5;
  localparam int HALF = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_c = 1'b0;
  logic         stop_n = 1'b1;
  logic [N-1:0] sw_dis = '0;
  logic         free_dis = 1'b0;
  logic         oe_n = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [N-1:0] gclk, gclk_oe;
  logic         free_clk, free_oe;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  clkstop_gate #(.N_GATED(N)) i_clkstop_gate (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_c), .stop_ni(stop_n),
    .sw_dis_i(sw_dis), .free_dis_i(free_dis), .oe_ni(oe_n), .mode_i(mode),
    .gclk_o(gclk), .gclk_oe_o(gclk_oe), .free_clk_o(free_clk), .free_oe_o(free_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One reference period; stop level is applied when the low phase starts.
  task automatic ref_period(input logic stop_lvl, output logic [N-1:0] g_hi,
                            output logic f_hi, output bit clean);
    clean = 1'b1;
    ref_c = 1'b1;
    for (int k = 0; k < HALF; k++) begin
      @(negedge clk);
      if (k == 0) begin g_hi = gclk; f_hi = free_clk; end
      else if (gclk !== g_hi || free_clk !== f_hi) clean = 1'b0;
    end
    ref_c = 1'b0;
    stop_n = stop_lvl;
    for (int k = 0; k < HALF; k++) begin
      @(negedge clk);
      if (gclk !== '0 || free_clk !== 1'b0) clean = 1'b0;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(gclk == '0 && !free_clk, "R1 clocks in reset", {gclk, free_clk}, 0);
    check(gclk_oe == '0 && !free_oe, "R1 enables in reset", {gclk_oe, free_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gclk_oe == '1 && free_oe, "R7 drivers on after reset", {gclk_oe, free_oe}, 6'h3f);
  endtask

  task automatic t_run;
    logic [N-1:0] g; logic f; bit c;
    for (int p = 0; p < 2; p++) begin
      ref_period(1'b1, g, f, c);
      check(g == '1 && f, "R10 running pulse", {g, f}, 6'h3f);
      check(c, "R5 no runt while running", c, 1);
    end
  endtask

  task automatic t_stop;
    logic [N-1:0] g; logic f; bit c;
    ref_period(1'b0, g, f, c);
    check(g == '1, "R2 request period still runs", g, 5'h1f);
    ref_period(1'b0, g, f, c);
    check(g == '1 && c, "R2 capture period still runs", g, 5'h1f);
    ref_period(1'b0, g, f, c);
    check(g == '0 && c, "R2 parked low", g, 0);
    check(f && c, "R4 free runs during stop", f, 1);
    check(gclk_oe == '1 && free_oe, "R9 parked yet driven", gclk_oe, 5'h1f);
    ref_period(1'b1, g, f, c);
    check(g == '0, "R2 still parked", g, 0);
  endtask

  task automatic t_release;
    logic [N-1:0] g; logic f; bit c;
    ref_period(1'b1, g, f, c);
    check(g == '0 && c, "R3 capture period still parked", g, 0);
    ref_period(1'b1, g, f, c);
    check(g == '1 && c, "R3 running again", g, 5'h1f);
  endtask

  task automatic t_swdis;
    logic [N-1:0] g; logic f; bit c;
    sw_dis = 5'b00101;
    ref_period(1'b1, g, f, c);
    check(g == 5'b11010 && c, "R6 disabled bits low", g, 5'h1a);
    check(gclk_oe == '1, "R9 disabled yet driven", gclk_oe, 5'h1f);
    sw_dis = '0;
    free_dis = 1'b1;
    ref_period(1'b1, g, f, c);
    check(g == '1 && !f, "R6 free disabled", {g, f}, 6'h3e);
    check(free_oe, "R9 free disabled yet driven", free_oe, 1);
    free_dis = 1'b0;
    ref_period(1'b1, g, f, c);
    check(f && g == '1, "R6 free re-enabled", {g, f}, 6'h3f);
  endtask

  task automatic t_oe;
    oe_n = 1'b0;
    @(negedge clk);
    check(gclk_oe == '0 && !free_oe, "R7 float on oe low", {gclk_oe, free_oe}, 0);
    oe_n = 1'b1;
    @(negedge clk);
    check(gclk_oe == '1 && free_oe, "R7 drive on oe high", {gclk_oe, free_oe}, 6'h3f);
  endtask

  task automatic t_mode;
    mode = 2'b11;
    @(negedge clk);
    check(gclk_oe == '0 && !free_oe, "R8 float code", {gclk_oe, free_oe}, 0);
    mode = 2'b01;
    @(negedge clk);
    check(gclk_oe == '1 && free_oe, "R8 code 01 drives", {gclk_oe, free_oe}, 6'h3f);
    mode = 2'b10;
    @(negedge clk);
    check(gclk_oe == '1 && free_oe, "R8 code 10 drives", {gclk_oe, free_oe}, 6'h3f);
    mode = 2'b00;
  endtask

  initial begin
    t_reset();
    t_run();
    t_stop();
    t_release();
    t_swdis();
    t_oe();
    t_mode();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule